// File: doc/BRIEF.md
# Universal Serial Shift Engine

An 8-bit serial shift engine that supplies the bit-level hardware for synchronous serial links. Wired one way, it acts as a three-wire (SPI-like) port. Wired the other way, it acts as a two-wire port with open-drain data and clock lines. Either form can run as master or slave. Software fills and drains a parallel shift register. A 4-bit edge counter reports when a byte or bit group is complete. A clock source picks which events move data: a software strobe, a timer-compare pulse, or the external clock pin with a chosen sampling edge.

The outgoing bit always comes from the register's most significant bit. It passes through a transparent latch, so in external-clock modes the output changes on the clock edge opposite to the sampling edge. Incoming bits always enter from the data input pin, whatever the wire mode. In two-wire mode the engine also does the following:
- It detects start and stop conditions.
- It stretches the clock line low while a start or overflow flag is pending, which gives software time to react.
- It provides an asynchronous wake signal for a start condition.

Top module: `sse_top`

Register map (2-bit address). Address 0 is control. Address 1 is status/count. Address 2 is the shift register. Address 3 reads 0.

## Requirements
- R1: After reset, addresses 0, 1 and 2 read 0x00. `irq_start_o`, `irq_ovf_o`, `do_o`, `sda_low_o` and `clk_low_o` are 0, and `sck_o` is 1.
- R2: The shift register (address 2) is written and read in parallel. A host write in the same cycle as a shift event wins.
- R3: Clock source 00 is set by control bits [3:2]. In this mode, each control write with bit 0 set shifts the register left by one. The synchronized `di_i` level enters bit 0, and the counter advances by 1. Timer pulses have no effect in this mode.
- R4: In clock source 01, each cycle with `tmr_cmp_i` high acts as one shift-and-count event. The software strobe bit has no effect in this mode and reads back as 0.
- R5: Clock source 10 samples `di_i` on rising `clk_pin_i` edges, and source 11 samples on falling edges. In both modes the counter advances on every edge of either polarity. Strobe and timer have no effect.
- R6: The counter is status bits [3:0] and is loaded by any status write. Wrapping from 15 to 0 sets the overflow flag (status bit 6). Writing 1 to a flag bit (7, 6, 5) clears that flag.
- R7: In sources 10 and 11, `do_o` follows the register MSB only while the clock pin sits at its pre-sample level. That level is low for source 10 and high for source 11. In sources 00 and 01, `do_o` follows the MSB continuously. `do_o` is 0 in two-wire mode.
- R8: Two-wire mode is control bit 4. In this mode, `sda_low_o` is the inverse of the latched MSB. In three-wire mode it is 0.
- R9: In two-wire mode, `di_i` falling while `clk_pin_i` is high sets the start flag (status bit 7). `di_i` rising while `clk_pin_i` is high sets the stop flag (status bit 5). Neither flag is set in three-wire mode.
- R10: In two-wire mode, `clk_low_o` is 1 while the start or overflow flag is set, or while `sck_o` is 0. It is released once these conditions clear.
- R11: Each control write with bit 1 set toggles `sck_o`.
- R12: `irq_start_o` is the start flag ANDed with control bit 7. `irq_ovf_o` is the overflow flag ANDed with control bit 6.
- R13: `wake_o` is high, with no clock needed, while two-wire mode and control bit 7 are set, `clk_pin_i` is high and `di_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| di_i | input | 1 | Serial data input / two-wire data line level |
| clk_pin_i | input | 1 | Clock pin level |
| tmr_cmp_i | input | 1 | Timer-compare pulse |
| do_o | output | 1 | Three-wire data out |
| sda_low_o | output | 1 | Pull two-wire data line low |
| sck_o | output | 1 | Software-toggled clock level |
| clk_low_o | output | 1 | Pull two-wire clock line low |
| irq_start_o | output | 1 | Start-condition interrupt |
| irq_ovf_o | output | 1 | Counter-overflow interrupt |
| wake_o | output | 1 | Asynchronous start wake |

## Verification
Several properties are checked on every cycle:
- The counter never moves by more than one step between host loads.
- A wrap always leaves the overflow flag set.
- In rising-sample mode the output latch holds while the clock is high.
- A start condition in two-wire mode always raises the start flag.
- Either pending flag keeps the clock line pulled low.

The actual bit values shifted in, the choice of which source moves data and which is ignored, the opposite-edge timing of the output bit, flag clearing, and the asynchronous wake level can only be shown by the directed scenarios, which compare read-back values and pins against expected patterns.

// File: rtl/sse_pkg.sv
// Shared encodings for the serial shift engine: clock-source selection,
// register addresses and control/status bit positions (8-bit register word).
package sse_pkg;
    typedef enum logic [1:0] {
        CS_SOFT     = 2'b00,
        CS_TIMER    = 2'b01,
        CS_EXT_RISE = 2'b10,
        CS_EXT_FALL = 2'b11
    } clk_src_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control word bit positions
    localparam int CB_STROBE   = 0;
    localparam int CB_TOGGLE   = 1;
    localparam int CB_SRC_LO   = 2;
    localparam int CB_TWO_WIRE = 4;
    localparam int CB_OVF_IE   = 6;
    localparam int CB_START_IE = 7;

    // status word bit positions
    localparam int SB_STOP  = 5;
    localparam int SB_OVF   = 6;
    localparam int SB_START = 7;
endpackage

// File: rtl/sse_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is an independent level; resets to zero.
module sse_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // shift the pin level one stage further into the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= async_i;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sse_events.sv
// Event generator: turns synchronized pin levels, the software strobe and the
// timer pulse into shift, count and latch-open qualifiers for the selected
// clock source, and detects two-wire start/stop conditions.
// Assumes pin inputs are already synchronized.
module sse_events
    import sse_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     s_clk,
    input  logic     s_di,
    input  clk_src_e clk_src,
    input  logic     two_wire,
    input  logic     sw_strobe,
    input  logic     tmr_cmp,
    output logic     shift_evt,
    output logic     count_evt,
    output logic     latch_open,
    output logic     start_evt,
    output logic     stop_evt,
    output logic     di_prev_o
);
    logic clk_prev_q, di_prev_q;
    logic clk_rise, clk_fall;

    // remember previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev_q <= 1'b0;
            di_prev_q  <= 1'b0;
        end else begin
            clk_prev_q <= s_clk;
            di_prev_q  <= s_di;
        end
    end

    assign clk_rise  = s_clk & ~clk_prev_q;
    assign clk_fall  = ~s_clk & clk_prev_q;
    assign di_prev_o = di_prev_q;

    // select shift/count/latch qualifiers for the active clock source
    always_comb begin
        unique case (clk_src)
            CS_SOFT: begin
                shift_evt  = sw_strobe;
                count_evt  = sw_strobe;
                latch_open = 1'b1;
            end
            CS_TIMER: begin
                shift_evt  = tmr_cmp;
                count_evt  = tmr_cmp;
                latch_open = 1'b1;
            end
            CS_EXT_RISE: begin
                shift_evt  = clk_rise;
                count_evt  = clk_rise | clk_fall;
                latch_open = ~s_clk;
            end
            default: begin
                shift_evt  = clk_fall;
                count_evt  = clk_rise | clk_fall;
                latch_open = s_clk;
            end
        endcase
    end

    // two-wire bus conditions: data moves while clock is high
    assign start_evt = two_wire & s_clk & di_prev_q & ~s_di;
    assign stop_evt  = two_wire & s_clk & ~di_prev_q & s_di;
endmodule

// File: rtl/sse_shifter.sv
// Data path: parallel-loadable shift register, MSB output latch and the
// wrapping edge counter. Host loads take priority over serial events.
// Assumes event inputs are single-cycle qualifiers.
module sse_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_evt,
    input  logic              count_evt,
    input  logic              latch_open,
    input  logic              ser_in,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [DATA_W-1:0] shreg_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              latch_o,
    output logic              ovf_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              latch_q;

    // shift register: host load wins, otherwise shift MSB-first
    always_ff @(posedge clk) begin
        if (!rst_n) shreg_q <= '0;
        else if (data_we) shreg_q <= data_wdata;
        else if (shift_evt) shreg_q <= {shreg_q[DATA_W-2:0], ser_in};
    end

    // output latch: follows the MSB only while open
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b0;
        else if (latch_open) latch_q <= shreg_q[DATA_W-1];
    end

    // edge counter: host load wins, otherwise wrap-increment
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (cnt_we) cnt_q <= cnt_wdata;
        else if (count_evt) cnt_q <= cnt_q + 1'b1;
    end

    assign ovf_evt = count_evt & ~cnt_we & (cnt_q == CNT_MAX);
    assign shreg_o = shreg_q;
    assign cnt_o   = cnt_q;
    assign latch_o = latch_q;
endmodule

// File: rtl/sse_top.sv
// Serial shift engine top: control register, flags, register port, pin
// drive and interrupts. Assumes an 8-bit register word (DATA_W = 8) and a
// counter no wider than the low nibble of the status word.
module sse_top
    import sse_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              di_i,
    input  logic              clk_pin_i,
    input  logic              tmr_cmp_i,
    output logic              do_o,
    output logic              sda_low_o,
    output logic              sck_o,
    output logic              clk_low_o,
    output logic              irq_start_o,
    output logic              irq_ovf_o,
    output logic              wake_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic              start_q, stop_q, ovf_q, sck_q;
    logic              ctrl_we, stat_we, data_we;
    logic              sw_strobe, two_wire;
    clk_src_e          clk_src;
    logic [1:0]        pins_sync;
    logic              s_clk, s_di, di_prev;
    logic              shift_evt, count_evt, latch_open, start_evt, stop_evt;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              latch_q, ovf_evt;
    logic [DATA_W-1:0] stat_word;
    wire               unused_bits = wr_data[CB_SRC_LO+2] ^ wr_data[SB_START-3];

    assign ctrl_we   = wr_en & (wr_addr == ADDR_CTRL);
    assign stat_we   = wr_en & (wr_addr == ADDR_STAT);
    assign data_we   = wr_en & (wr_addr == ADDR_DATA);
    assign sw_strobe = ctrl_we & wr_data[CB_STROBE];
    assign two_wire  = ctrl_q[CB_TWO_WIRE];
    assign clk_src   = clk_src_e'(ctrl_q[CB_SRC_LO +: 2]);

    sse_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({clk_pin_i, di_i}), .sync_o(pins_sync)
    );
    assign {s_clk, s_di} = pins_sync;

    sse_events u_events (
        .clk(clk), .rst_n(rst_n), .s_clk(s_clk), .s_di(s_di),
        .clk_src(clk_src), .two_wire(two_wire), .sw_strobe(sw_strobe),
        .tmr_cmp(tmr_cmp_i), .shift_evt(shift_evt), .count_evt(count_evt),
        .latch_open(latch_open), .start_evt(start_evt), .stop_evt(stop_evt),
        .di_prev_o(di_prev)
    );

    sse_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .count_evt(count_evt),
        .latch_open(latch_open), .ser_in(s_di), .data_we(data_we),
        .data_wdata(wr_data), .cnt_we(stat_we), .cnt_wdata(wr_data[CNT_W-1:0]),
        .shreg_o(shreg), .cnt_o(cnt), .latch_o(latch_q), .ovf_evt(ovf_evt)
    );

    // control register: strobe and toggle bits are actions, not storage
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= {wr_data[DATA_W-1:CB_SRC_LO], 2'b00};
    end

    // software clock level, toggled by control writes
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b1;
        else if (ctrl_we && wr_data[CB_TOGGLE]) sck_q <= ~sck_q;
    end

    // flags: write-one-to-clear, a same-cycle set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            stop_q  <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            if (stat_we && wr_data[SB_START]) start_q <= 1'b0;
            if (stat_we && wr_data[SB_STOP])  stop_q  <= 1'b0;
            if (stat_we && wr_data[SB_OVF])   ovf_q   <= 1'b0;
            if (start_evt) start_q <= 1'b1;
            if (stop_evt)  stop_q  <= 1'b1;
            if (ovf_evt)   ovf_q   <= 1'b1;
        end
    end

    // assemble the status word from flags and counter
    always_comb begin
        stat_word           = '0;
        stat_word[SB_START] = start_q;
        stat_word[SB_OVF]   = ovf_q;
        stat_word[SB_STOP]  = stop_q;
        stat_word[CNT_W-1:0] = cnt;
    end

    // register read mux
    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL: rd_data = ctrl_q;
            ADDR_STAT: rd_data = stat_word;
            ADDR_DATA: rd_data = shreg;
            default:   rd_data = '0;
        endcase
    end

    assign do_o        = ~two_wire & latch_q;
    assign sda_low_o   = two_wire & ~latch_q;
    assign sck_o       = sck_q;
    assign clk_low_o   = two_wire & (start_q | ovf_q | ~sck_q);
    assign irq_start_o = start_q & ctrl_q[CB_START_IE];
    assign irq_ovf_o   = ovf_q & ctrl_q[CB_OVF_IE];
    assign wake_o      = two_wire & ctrl_q[CB_START_IE] & clk_pin_i & ~di_i;
endmodule

// File: rtl/sse_checker.sv
// Property checker for sse_top, attached by bind. Observes internal state
// driven by separate submodules and the top-level pins.
module sse_checker
    import sse_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input clk_src_e         clk_src,
    input logic             s_clk,
    input logic             s_di,
    input logic             di_prev,
    input logic             latch_q,
    input logic [CNT_W-1:0] cnt,
    input logic             stat_we,
    input logic             count_evt,
    input logic             ovf_q,
    input logic             start_q,
    input logic             two_wire,
    input logic             clk_low_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R6: counter moves at most one step unless loaded
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_we) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6: wrap always leaves overflow flag set
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_evt && !stat_we && cnt == CNT_MAX |=> ovf_q);

    // R7: rising-sample mode keeps latch closed while clock high
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_src) == CS_EXT_RISE && $past(s_clk)) |-> $stable(latch_q));

    // R9: start condition in two-wire mode raises start flag
    p_start_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        two_wire && s_clk && di_prev && !s_di |=> start_q);

    // R10: pending flag in two-wire mode stretches the clock
    p_clock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        two_wire && (ovf_q || start_q) |-> clk_low_o);
endmodule

bind sse_top sse_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .s_clk(s_clk), .s_di(s_di),
    .di_prev(di_prev), .latch_q(latch_q), .cnt(cnt), .stat_we(stat_we),
    .count_evt(count_evt), .ovf_q(ovf_q), .start_q(start_q),
    .two_wire(two_wire), .clk_low_o(clk_low_o)
);

// File: tb/tb_sse_top.sv
`timescale 1ns/1ps
module tb_sse_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       di_i = 1'b0, clk_pin_i = 1'b0, tmr_cmp_i = 1'b0;
    logic       do_o, sda_low_o, sck_o, clk_low_o, irq_start_o, irq_ovf_o, wake_o;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    always #2 clk = ~clk;

    sse_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .di_i(di_i), .clk_pin_i(clk_pin_i), .tmr_cmp_i(tmr_cmp_i),
        .do_o(do_o), .sda_low_o(sda_low_o), .sck_o(sck_o),
        .clk_low_o(clk_low_o), .irq_start_o(irq_start_o),
        .irq_ovf_o(irq_ovf_o), .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #0.5 d = rd_data;
    endtask

    task automatic tmr_pulse();
        @(negedge clk);
        tmr_cmp_i = 1'b1;
        @(negedge clk);
        tmr_cmp_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 status", v, 8'h00);
        rd(2'd2, v); chk("R1 data", v, 8'h00);
        chk("R1 pins", {irq_start_o, irq_ovf_o, do_o, sda_low_o, clk_low_o, sck_o},
            8'h01);
    endtask

    task automatic t_soft();
        logic [7:0] v;
        wr(2'd0, 8'h00); wr(2'd1, 8'hE0); wr(2'd2, 8'h5C);
        rd(2'd2, v); chk("R2 parallel rw", v, 8'h5C);
        wr(2'd2, 8'h00);
        di_i = 1'b1; wait_n(3); wr(2'd0, 8'h01);
        di_i = 1'b0; wait_n(3); wr(2'd0, 8'h01);
        di_i = 1'b1; wait_n(3); wr(2'd0, 8'h01);
        rd(2'd2, v); chk("R3 soft shift", v, 8'h05);
        rd(2'd1, v); chk("R3 soft count", v, 8'h03);
        wait_n(2); chk("R7 do internal low", {7'd0, do_o}, 8'h00);
        wr(2'd2, 8'h80); wait_n(2);
        chk("R7 do follows msb", {7'd0, do_o}, 8'h01);
        tmr_pulse();
        rd(2'd2, v); chk("R3 timer ignored", v, 8'h80);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr(2'd0, 8'h04); wr(2'd1, 8'hE0); wr(2'd2, 8'h00);
        tmr_pulse(); tmr_pulse();
        rd(2'd2, v); chk("R4 timer shift", v, 8'h03);
        rd(2'd1, v); chk("R4 timer count", v, 8'h02);
        wr(2'd0, 8'h05);
        rd(2'd2, v); chk("R4 strobe ignored", v, 8'h03);
        rd(2'd0, v); chk("R4 ctrl readback", v, 8'h04);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h77; tmr_cmp_i = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tmr_cmp_i = 1'b0;
        rd(2'd2, v); chk("R2 write beats shift", v, 8'h77);
    endtask

    task automatic t_ext_rise();
        logic [7:0] v;
        logic [7:0] pattern = 8'h5A;
        wr(2'd0, 8'h00); clk_pin_i = 1'b0; wait_n(5);
        wr(2'd0, 8'h08); wr(2'd1, 8'hE0); wr(2'd2, 8'h43); wait_n(3);
        for (int i = 7; i >= 0; i--) begin
            di_i = pattern[i]; wait_n(3);
            clk_pin_i = 1'b1; wait_n(5);
            if (i == 7) begin
                chk("R7 latch holds on sample edge", {7'd0, do_o}, 8'h00);
                rd(2'd1, v); chk("R5 count after rise", v, 8'h01);
            end
            clk_pin_i = 1'b0; wait_n(5);
            if (i == 7) begin
                chk("R7 latch opens on opposite edge", {7'd0, do_o}, 8'h01);
                rd(2'd1, v); chk("R5 count after fall", v, 8'h02);
            end
        end
        rd(2'd2, v); chk("R5 rising capture", v, 8'h5A);
        rd(2'd1, v); chk("R6 overflow after 16 edges", v, 8'h40);
        wr(2'd0, 8'h09); tmr_pulse();
        rd(2'd2, v); chk("R5 strobe and timer ignored", v, 8'h5A);
        wr(2'd0, 8'h48);
        chk("R12 ovf irq", {7'd0, irq_ovf_o}, 8'h01);
        wr(2'd1, 8'h40);
        chk("R12 ovf irq cleared", {7'd0, irq_ovf_o}, 8'h00);
        rd(2'd1, v); chk("R6 write one clears", v, 8'h00);
    endtask

    task automatic t_ext_fall();
        logic [7:0] v;
        wr(2'd0, 8'h00); clk_pin_i = 1'b1; wait_n(5);
        wr(2'd0, 8'h0C); wr(2'd1, 8'hE0); wr(2'd2, 8'h00);
        di_i = 1'b1; wait_n(3);
        clk_pin_i = 1'b0; wait_n(5);
        rd(2'd2, v); chk("R5 falling capture", v, 8'h01);
        rd(2'd1, v); chk("R5 count fall mode", v, 8'h01);
        clk_pin_i = 1'b1; wait_n(5);
        rd(2'd2, v); chk("R5 no capture on rise", v, 8'h01);
        rd(2'd1, v); chk("R5 count both edges", v, 8'h02);
    endtask

    task automatic t_two_wire();
        logic [7:0] v;
        wr(2'd0, 8'h00); clk_pin_i = 1'b1; di_i = 1'b1; wait_n(5);
        wr(2'd0, 8'h90); wr(2'd1, 8'hE0);
        wr(2'd2, 8'hFF); wait_n(3);
        chk("R8 line released", {6'd0, sda_low_o, clk_low_o}, 8'h00);
        chk("R7 do quiet in two-wire", {7'd0, do_o}, 8'h00);
        wr(2'd2, 8'h00); wait_n(3);
        chk("R8 line pulled", {7'd0, sda_low_o}, 8'h01);
        @(negedge clk); di_i = 1'b0; #0.5;
        chk("R13 async wake", {7'd0, wake_o}, 8'h01);
        wait_n(5);
        rd(2'd1, v); chk("R9 start flag", v, 8'h80);
        chk("R12 start irq", {7'd0, irq_start_o}, 8'h01);
        chk("R10 hold on start", {7'd0, clk_low_o}, 8'h01);
        wr(2'd1, 8'h80);
        chk("R10 release after clear", {6'd0, clk_low_o, irq_start_o}, 8'h00);
        di_i = 1'b1; wait_n(5);
        rd(2'd1, v); chk("R9 stop flag", v, 8'h20);
        wr(2'd1, 8'h2F); wr(2'd0, 8'h91);
        rd(2'd1, v); chk("R6 preload wrap", v, 8'h40);
        chk("R10 hold on overflow", {7'd0, clk_low_o}, 8'h01);
        wr(2'd1, 8'h40);
        chk("R10 overflow release", {7'd0, clk_low_o}, 8'h00);
        wr(2'd0, 8'h92);
        chk("R11 toggle low", {6'd0, sck_o, clk_low_o}, 8'h01);
        wr(2'd0, 8'h92);
        chk("R11 toggle high", {6'd0, sck_o, clk_low_o}, 8'h02);
        wr(2'd0, 8'h00);
        @(negedge clk); di_i = 1'b0; #0.5;
        chk("R13 no wake in three-wire", {7'd0, wake_o}, 8'h00);
        wait_n(5);
        rd(2'd1, v); chk("R9 no start in three-wire", v, 8'h00);
        chk("R8 no pull in three-wire", {7'd0, sda_low_o}, 8'h00);
        di_i = 1'b1; wait_n(5);
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        t_reset();
        t_soft();
        t_timer();
        t_ext_rise();
        t_ext_fall();
        t_two_wire();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule